// File: doc/BRIEF.md
# 16-bit ALU with Status Flag Update

This block is the purely combinational arithmetic and logic stage of a small 16-bit processor. It takes a destination operand, a source operand, a 4-bit operation code, a byte/word size select and the current status word. From these it returns three things: the result, a strobe that says whether the result should be written back, and the next status word. Each operation updates only its own subset of the carry, zero, negative and overflow flags. Every other status bit passes through unchanged.

The operations cover binary add and subtract, each with and without the incoming carry, and a compare. There is also a packed-BCD decimal add, four bitwise operations, two right rotates and two word-only byte manipulations. A separate condition evaluator reads the incoming status word and reports whether a conditional branch selected by a 3-bit code is taken. Operand fetch, writeback and the register file sit around the block and are not part of it.

Top module: `flag_alu`

## Requirements
- R1: `op_i` encodes ADD=0, ADDC=1, SUB=2, SUBC=3, CMP=4, DADD=5, AND=6, BIT=7, BIC=8, BIS=9, XOR=10, RRC=11, RRA=12, SWPB=13, SXT=14. Code 15 is a no-op. `wr_o` is 0 for CMP, BIT and code 15, and 1 for every other code.
- R2: The status word holds C in bit 0, Z in bit 1, N in bit 2 and V in bit 8. Every other bit of `sr_i` appears unchanged on `sr_o`.
- R3: ADD computes dst+src and ADDC computes dst+src+C. C is the unsigned carry out of the operand size. V is set when the signed sum does not fit. N is the sign bit of the result and Z flags a zero result.
- R4: SUB computes dst+~src+1 and SUBC computes dst+~src+C. C=1 means no borrow. V is set on signed overflow. CMP sets the flags exactly as SUB does.
- R5: With `byte_i`=1, both operands are cut to bits 7:0, `res_o[15:8]` is 0, N is taken from bit 7, and Z and C refer to 8 bits. This holds for all codes except SWPB and SXT, which always work on words.
- R6: DADD adds the operands as packed BCD digits plus C: 4 digits in word mode, 2 in byte mode. C is set when the decimal sum exceeds 9999 in word mode or 99 in byte mode. The result holds the low digits. N and Z are updated and V is unchanged.
- R7: AND and BIT set C when the result is nonzero and clear V. BIT produces no write. BIC (dst & ~src) and BIS (dst | src) leave the whole status word unchanged.
- R8: XOR sets V when both operands are negative, and sets C when the result is nonzero.
- R9: RRC shifts right, with the old C entering the size's top bit. RRA shifts right and keeps the sign bit. Both move the old bit 0 into C and clear V.
- R10: SWPB exchanges the two bytes of `dst_i` and leaves all flags unchanged. SXT copies bit 7 of `dst_i` into bits 15:8, sets N from bit 15 and Z on zero, sets C to the inverse of Z and clears V.
- R11: `take_o` is evaluated from `sr_i` with `cond_i`: 0 = Z clear, 1 = Z set, 2 = C clear, 3 = C set, 4 = N set, 5 = N equals V, 6 = N differs from V, 7 = always.
- R12: For code 15 the result is the size-masked `dst_i` and `sr_o` equals `sr_i`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dst_i | input | 16 | Destination operand; sole operand of single-operand codes |
| src_i | input | 16 | Source operand |
| op_i | input | 4 | Operation code |
| byte_i | input | 1 | 1 selects byte size, 0 word size |
| sr_i | input | 16 | Current status word |
| cond_i | input | 3 | Branch condition select |
| res_o | output | 16 | Operation result |
| wr_o | output | 1 | Result should be written back |
| sr_o | output | 16 | Next status word |
| take_o | output | 1 | Branch condition is met |

## Verification
Additions and subtractions are driven at the signed and unsigned boundaries: 0x7FFF+1, 0xFFFF+1, 0x8000-1 and their byte equivalents. These points separate carry from overflow and also expose any confusion between borrow and no-borrow. Decimal adds are driven with sums just below and just above 99 and 9999 to pin down where the decimal carry begins. Shifts and logic operations use operands with the sign and low bits set. They run with the incoming C both set and clear, so that every flag each operation does or does not own is actually observed. A mixed stream of random operands then covers every code in both sizes, using valid BCD for the decimal add.

// File: rtl/flag_alu.sv
module flag_alu (
  input  logic [15:0] dst_i,
  input  logic [15:0] src_i,
  input  logic [3:0]  op_i,
  input  logic        byte_i,
  input  logic [15:0] sr_i,
  input  logic [2:0]  cond_i,
  output logic [15:0] res_o,
  output logic        wr_o,
  output logic [15:0] sr_o,
  output logic        take_o
);
  localparam logic [3:0] OP_ADD = 4'd0, OP_ADDC = 4'd1, OP_SUB = 4'd2, OP_SUBC = 4'd3,
                         OP_CMP = 4'd4, OP_DADD = 4'd5, OP_AND = 4'd6, OP_BIT = 4'd7,
                         OP_BIC = 4'd8, OP_BIS = 4'd9, OP_XOR = 4'd10, OP_RRC = 4'd11,
                         OP_RRA = 4'd12, OP_SWPB = 4'd13, OP_SXT = 4'd14;
  localparam int BC = 0, BZ = 1, BN = 2, BV = 8;
  localparam int DIGITS = 4;

  logic [15:0] msk, sgnm, a, s, b;
  logic        is_sub, cin;
  logic [16:0] sum;
  logic        add_c, add_v;

  assign msk    = byte_i ? 16'h00FF : 16'hFFFF;
  assign sgnm   = byte_i ? 16'h0080 : 16'h8000;
  assign a      = dst_i & msk;
  assign s      = src_i & msk;
  assign is_sub = (op_i == OP_SUB) || (op_i == OP_SUBC) || (op_i == OP_CMP);
  assign b      = is_sub ? (~src_i & msk) : s;
  assign cin    = (op_i == OP_SUB || op_i == OP_CMP) ? 1'b1 :
                  (op_i == OP_ADDC || op_i == OP_SUBC) ? sr_i[BC] : 1'b0;
  assign sum    = {1'b0, a} + {1'b0, b} + {16'b0, cin};
  assign add_c  = byte_i ? sum[8] : sum[16];
  assign add_v  = (|(a & sgnm) == |(b & sgnm)) && (|(sum[15:0] & sgnm) != |(a & sgnm));

  logic [DIGITS:0]   dcar;
  logic [4:0]        draw [DIGITS];
  logic [4:0]        dadj [DIGITS];
  logic [15:0]       dsum;
  logic              dadd_c;

  assign dcar[0] = sr_i[BC];
  for (genvar g = 0; g < DIGITS; g++) begin : g_digit
    assign draw[g]      = {1'b0, a[4*g +: 4]} + {1'b0, s[4*g +: 4]} + {4'b0, dcar[g]};
    assign dadj[g]      = draw[g] - 5'd10;
    assign dcar[g+1]    = draw[g] > 5'd9;
    assign dsum[4*g +: 4] = dcar[g+1] ? dadj[g][3:0] : draw[g][3:0];
  end
  assign dadd_c = byte_i ? dcar[2] : dcar[DIGITS];

  logic [15:0] res;
  logic        wr, word_only, upd_nz, upd_c, upd_v, c_is_nz, nc, nv, nz, nn;

  always_comb begin
    res       = a;
    wr        = 1'b1;
    word_only = 1'b0;
    upd_nz    = 1'b0;
    upd_c     = 1'b0;
    upd_v     = 1'b0;
    c_is_nz   = 1'b0;
    nc        = sr_i[BC];
    nv        = sr_i[BV];
    case (op_i)
      OP_ADD, OP_ADDC, OP_SUB, OP_SUBC, OP_CMP: begin
        res = sum[15:0] & msk;
        nc  = add_c;
        nv  = add_v;
        {upd_nz, upd_c, upd_v} = 3'b111;
        wr  = (op_i != OP_CMP);
      end
      OP_DADD: begin
        res = dsum & msk;
        nc  = dadd_c;
        {upd_nz, upd_c} = 2'b11;
      end
      OP_AND, OP_BIT: begin
        res = a & s;
        c_is_nz = 1'b1;
        nv  = 1'b0;
        {upd_nz, upd_c, upd_v} = 3'b111;
        wr  = (op_i == OP_AND);
      end
      OP_BIC: res = a & ~s;
      OP_BIS: res = a | s;
      OP_XOR: begin
        res = a ^ s;
        c_is_nz = 1'b1;
        nv  = |(a & sgnm) & |(s & sgnm);
        {upd_nz, upd_c, upd_v} = 3'b111;
      end
      OP_RRC, OP_RRA: begin
        res = {1'b0, a[15:1]};
        if (op_i == OP_RRC) res = res | (sr_i[BC] ? sgnm : 16'h0000);
        else                res = res | (a & sgnm);
        nc  = a[0];
        nv  = 1'b0;
        {upd_nz, upd_c, upd_v} = 3'b111;
      end
      OP_SWPB: begin
        res = {dst_i[7:0], dst_i[15:8]};
        word_only = 1'b1;
      end
      OP_SXT: begin
        res = {{8{dst_i[7]}}, dst_i[7:0]};
        word_only = 1'b1;
        c_is_nz = 1'b1;
        nv  = 1'b0;
        {upd_nz, upd_c, upd_v} = 3'b111;
      end
      default: wr = 1'b0;
    endcase
    nz = (res == 16'h0000);
    nn = word_only ? res[15] : |(res & sgnm);
    if (c_is_nz) nc = ~nz;
  end

  always_comb begin
    sr_o = sr_i;
    if (upd_nz) begin
      sr_o[BN] = nn;
      sr_o[BZ] = nz;
    end
    if (upd_c) sr_o[BC] = nc;
    if (upd_v) sr_o[BV] = nv;
  end

  assign res_o = res;
  assign wr_o  = wr;

  always_comb begin
    case (cond_i)
      3'd0:    take_o = ~sr_i[BZ];
      3'd1:    take_o = sr_i[BZ];
      3'd2:    take_o = ~sr_i[BC];
      3'd3:    take_o = sr_i[BC];
      3'd4:    take_o = sr_i[BN];
      3'd5:    take_o = (sr_i[BN] == sr_i[BV]);
      3'd6:    take_o = (sr_i[BN] != sr_i[BV]);
      default: take_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/flag_alu_chk.sv
module flag_alu_chk (
  input logic [15:0] dst_i,
  input logic [15:0] src_i,
  input logic [3:0]  op_i,
  input logic        byte_i,
  input logic [15:0] sr_i,
  input logic [2:0]  cond_i,
  input logic [15:0] res_o,
  input logic        wr_o,
  input logic [15:0] sr_o,
  input logic        take_o
);
  always_comb begin
    if (!$isunknown({dst_i, src_i, op_i, byte_i, sr_i, cond_i})) begin
      // R1
      if (op_i == 4'd4 || op_i == 4'd7 || op_i == 4'd15)
        nowrite_chk: assert (!wr_o);
      // R7
      if (op_i == 4'd8 || op_i == 4'd9 || op_i == 4'd13 || op_i == 4'd15)
        flags_kept_chk: assert (sr_o == sr_i);
      // R5
      if (byte_i && op_i != 4'd13 && op_i != 4'd14)
        byte_clean_chk: assert (res_o[15:8] == 8'h00);
      // R11
      if (cond_i == 3'd7)
        always_taken_chk: assert (take_o);
      // R2
      other_bits_chk: assert ((sr_o & 16'hFEF8) == (sr_i & 16'hFEF8));
      // R3
      if (op_i <= 4'd3 && !byte_i)
        zero_flag_chk: assert (sr_o[1] == (res_o == 16'h0000));
    end
  end
endmodule

bind flag_alu flag_alu_chk u_chk (
  .dst_i(dst_i), .src_i(src_i), .op_i(op_i), .byte_i(byte_i), .sr_i(sr_i),
  .cond_i(cond_i), .res_o(res_o), .wr_o(wr_o), .sr_o(sr_o), .take_o(take_o)
);

// File: tb/sim_flag_alu.sv
module sim_flag_alu;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [15:0] dst, src, sr;
  logic [3:0]  op;
  logic        byt;
  logic [2:0]  cond;
  logic [15:0] res_o, sr_o;
  logic        wr_o, take_o;

  flag_alu u0 (.dst_i(dst), .src_i(src), .op_i(op), .byte_i(byt), .sr_i(sr),
               .cond_i(cond), .res_o(res_o), .wr_o(wr_o), .sr_o(sr_o), .take_o(take_o));

  typedef struct {
    logic [15:0] res;
    logic        wr;
    logic [15:0] sr;
    logic        take;
    string       tag;
  } item_t;

  item_t sbq[$];
  int total = 0, bad = 0;
  bit done = 0;

  function automatic int sx(int v, bit b);
    if (b) return (v & 128) ? v - 256 : v;
    return (v & 32768) ? v - 65536 : v;
  endfunction

  function automatic int bcd2bin(int v);
    return (v & 15) + ((v >> 4) & 15) * 10 + ((v >> 8) & 15) * 100 + ((v >> 12) & 15) * 1000;
  endfunction

  function automatic int bin2bcd(int v);
    return (v % 10) | (((v / 10) % 10) << 4) | (((v / 100) % 10) << 8) | (((v / 1000) % 10) << 12);
  endfunction

  function automatic item_t model(logic [15:0] d, logic [15:0] s, logic [3:0] o,
                                  logic b, logic [15:0] si, logic [2:0] cd);
    item_t it;
    int mask = b ? 255 : 65535;
    int sb   = b ? 128 : 32768;
    int u1 = int'(d) & mask;
    int u2 = int'(s) & mask;
    int c  = int'(si[0]);
    int r = 0, ures, sres, cin, tot, lim, sgn;
    bit fn = 0, fc = 0, fv = 0, nc, nv, wordop = 0;
    it.wr = 1'b1;
    it.sr = si;
    nc = si[0];
    nv = si[8];
    case (o)
      4'd0, 4'd1: begin
        cin  = (o == 4'd1) ? c : 0;
        ures = u1 + u2 + cin;
        sres = sx(u1, b) + sx(u2, b) + cin;
        r = ures & mask; nc = ures > mask; nv = (sres > sb - 1) || (sres < -sb);
        fn = 1; fc = 1; fv = 1;
      end
      4'd2, 4'd3, 4'd4: begin
        cin  = (o == 4'd3) ? c : 1;
        ures = u1 + ((~u2) & mask) + cin;
        sres = sx(u1, b) - sx(u2, b) - 1 + cin;
        r = ures & mask; nc = ures > mask; nv = (sres > sb - 1) || (sres < -sb);
        fn = 1; fc = 1; fv = 1;
        if (o == 4'd4) it.wr = 1'b0;
      end
      4'd5: begin
        lim = b ? 99 : 9999;
        tot = bcd2bin(u1) + bcd2bin(u2) + c;
        nc = tot > lim;
        r = bin2bcd(tot % (lim + 1)) & mask;
        fn = 1; fc = 1;
      end
      4'd6, 4'd7: begin
        r = u1 & u2; nc = r != 0; nv = 0;
        fn = 1; fc = 1; fv = 1;
        if (o == 4'd7) it.wr = 1'b0;
      end
      4'd8: r = u1 & (~u2) & mask;
      4'd9: r = u1 | u2;
      4'd10: begin
        r = u1 ^ u2; nc = r != 0; nv = ((u1 & sb) != 0) && ((u2 & sb) != 0);
        fn = 1; fc = 1; fv = 1;
      end
      4'd11: begin
        r = (u1 >> 1) | (c != 0 ? sb : 0); nc = (u1 & 1) != 0; nv = 0;
        fn = 1; fc = 1; fv = 1;
      end
      4'd12: begin
        r = (u1 >> 1) | (u1 & sb); nc = (u1 & 1) != 0; nv = 0;
        fn = 1; fc = 1; fv = 1;
      end
      4'd13: begin
        r = ((int'(d) >> 8) & 255) | ((int'(d) & 255) << 8);
        wordop = 1;
      end
      4'd14: begin
        r = d[7] ? ((int'(d) & 255) | 65280) : (int'(d) & 255);
        wordop = 1; nc = r != 0; nv = 0;
        fn = 1; fc = 1; fv = 1;
      end
      default: begin
        r = u1; it.wr = 1'b0;
      end
    endcase
    sgn = wordop ? 32768 : sb;
    if (fn) begin
      it.sr[2] = (r & sgn) != 0;
      it.sr[1] = (r == 0);
    end
    if (fc) it.sr[0] = nc;
    if (fv) it.sr[8] = nv;
    it.res = r[15:0];
    case (cd)
      3'd0: it.take = !si[1];
      3'd1: it.take = si[1];
      3'd2: it.take = !si[0];
      3'd3: it.take = si[0];
      3'd4: it.take = si[2];
      3'd5: it.take = (si[2] == si[8]);
      3'd6: it.take = (si[2] != si[8]);
      default: it.take = 1'b1;
    endcase
    return it;
  endfunction

  task automatic apply(input logic [15:0] d, input logic [15:0] s, input logic [3:0] o,
                       input logic b, input logic [15:0] si, input logic [2:0] cd, input string tag);
    item_t it;
    @(posedge clk);
    #1;
    dst = d; src = s; op = o; byt = b; sr = si; cond = cd;
    it = model(d, s, o, b, si, cd);
    it.tag = tag;
    sbq.push_back(it);
  endtask

  initial begin : monitor
    item_t e;
    forever begin
      @(negedge clk);
      if (sbq.size() > 0) begin
        e = sbq.pop_front();
        total++;
        if (res_o !== e.res || wr_o !== e.wr || sr_o !== e.sr || take_o !== e.take) begin
          bad++;
          $display("FAIL %s: res=%h wr=%b sr=%h take=%b expected res=%h wr=%b sr=%h take=%b",
                   e.tag, res_o, wr_o, sr_o, take_o, e.res, e.wr, e.sr, e.take);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    logic [3:0] ro;
    logic       rb;
    logic [15:0] rd, rs, rsr;
    dst = 0; src = 0; op = 4'd15; byt = 0; sr = 0; cond = 3'd7;
    apply(16'h1234, 16'h0000, 4'd15, 1'b0, 16'h0000, 3'd7, "R12 idle no-op word");
    apply(16'h1234, 16'h5678, 4'd15, 1'b1, 16'h0107, 3'd0, "R12 no-op byte keeps flags");
    apply(16'h7FFF, 16'h0001, 4'd0, 1'b0, 16'h0000, 3'd7, "R3 add signed overflow");
    apply(16'hFFFF, 16'h0001, 4'd0, 1'b0, 16'h0000, 3'd7, "R3 add carry zero");
    apply(16'h1000, 16'h2000, 4'd1, 1'b0, 16'h0001, 3'd7, "R3 addc with carry");
    apply(16'h007F, 16'h0001, 4'd0, 1'b1, 16'h0000, 3'd7, "R5 byte add overflow");
    apply(16'hAAFF, 16'hBB01, 4'd0, 1'b1, 16'hF000, 3'd7, "R5 byte add carry masks upper");
    apply(16'h0005, 16'h0003, 4'd2, 1'b0, 16'h0000, 3'd7, "R4 sub no borrow");
    apply(16'h0003, 16'h0005, 4'd2, 1'b0, 16'h0000, 3'd7, "R4 sub borrow");
    apply(16'h8000, 16'h0001, 4'd2, 1'b0, 16'h0000, 3'd7, "R4 sub overflow");
    apply(16'h0005, 16'h0005, 4'd3, 1'b0, 16'h0000, 3'd7, "R4 subc carry clear");
    apply(16'h0005, 16'h0005, 4'd3, 1'b0, 16'h0001, 3'd7, "R4 subc carry set");
    apply(16'h0042, 16'h0042, 4'd4, 1'b0, 16'h0000, 3'd7, "R4 cmp equal no write");
    apply(16'h0080, 16'h0001, 4'd4, 1'b1, 16'h0000, 3'd7, "R4 byte cmp overflow");
    apply(16'h9999, 16'h0001, 4'd5, 1'b0, 16'h0100, 3'd7, "R6 dadd word wrap");
    apply(16'h4998, 16'h5000, 4'd5, 1'b0, 16'h0001, 3'd7, "R6 dadd word 9999 no carry");
    apply(16'h0045, 16'h0054, 4'd5, 1'b1, 16'h0000, 3'd7, "R6 dadd byte 99");
    apply(16'h0045, 16'h0054, 4'd5, 1'b1, 16'h0001, 3'd7, "R6 dadd byte 100");
    apply(16'hF0F0, 16'h0F0F, 4'd6, 1'b0, 16'h0100, 3'd7, "R7 and zero");
    apply(16'hF0F0, 16'h8080, 4'd7, 1'b0, 16'h0100, 3'd7, "R7 bit nonzero no write");
    apply(16'hFFFF, 16'h00F0, 4'd8, 1'b0, 16'h0006, 3'd7, "R7 bic flags kept");
    apply(16'h0000, 16'h0000, 4'd9, 1'b0, 16'h0101, 3'd7, "R7 bis zero flags kept");
    apply(16'h8001, 16'h8000, 4'd10, 1'b0, 16'h0000, 3'd7, "R8 xor both negative");
    apply(16'h1234, 16'h1234, 4'd10, 1'b0, 16'h0001, 3'd7, "R8 xor zero");
    apply(16'h0081, 16'h0000, 4'd11, 1'b1, 16'h0001, 3'd7, "R9 rrc byte carry in");
    apply(16'h8000, 16'h0000, 4'd11, 1'b0, 16'h0100, 3'd7, "R9 rrc word no carry");
    apply(16'h8001, 16'h0000, 4'd12, 1'b0, 16'h0000, 3'd7, "R9 rra word sign kept");
    apply(16'h0081, 16'h0000, 4'd12, 1'b1, 16'h0100, 3'd7, "R9 rra byte");
    apply(16'h12AB, 16'h0000, 4'd13, 1'b0, 16'h0106, 3'd7, "R10 swpb");
    apply(16'h12AB, 16'h0000, 4'd13, 1'b1, 16'h0000, 3'd7, "R10 swpb ignores byte");
    apply(16'h1280, 16'h0000, 4'd14, 1'b0, 16'h0100, 3'd7, "R10 sxt negative");
    apply(16'hFF00, 16'h0000, 4'd14, 1'b1, 16'h0001, 3'd7, "R10 sxt zero");
    apply(16'h0000, 16'h0000, 4'd15, 1'b0, 16'hFEF8, 3'd7, "R2 other bits pass");
    for (int c = 0; c < 8; c++) begin
      apply(16'h0, 16'h0, 4'd15, 1'b0, 16'h0000, 3'(c), "R11 cond flags clear");
      apply(16'h0, 16'h0, 4'd15, 1'b0, 16'h0107, 3'(c), "R11 cond flags set");
      apply(16'h0, 16'h0, 4'd15, 1'b0, 16'h0004, 3'(c), "R11 cond N only");
      apply(16'h0, 16'h0, 4'd15, 1'b0, 16'h0100, 3'(c), "R11 cond V only");
    end
    for (int op_code = 0; op_code < 16; op_code++)
      apply(16'h8421, 16'h1248, 4'(op_code), 1'b0, 16'h0000, 3'd7, "R1 write strobe per code");
    for (int i = 0; i < 400; i++) begin
      ro  = 4'($urandom_range(0, 15));
      rb  = 1'($urandom_range(0, 1));
      rd  = 16'($urandom);
      rs  = 16'($urandom);
      rsr = 16'($urandom);
      if (ro == 4'd5) begin
        rd = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9)), 4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
        rs = {4'($urandom_range(0, 9)), 4'($urandom_range(0, 9)), 4'($urandom_range(0, 9)), 4'($urandom_range(0, 9))};
      end
      apply(rd, rs, ro, rb, rsr, 3'($urandom_range(0, 7)), $sformatf("R5 random op %0d byte %0d", ro, rb));
    end
    repeat (3) @(posedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule